// File: doc/BRIEF.md
# Programmable Down-Counting Timer Core

This block is one memory-mapped timer that counts down. A system clock drives all of its registers. A separate tick input gates the counting, and a prescaler can divide that tick further by 1, 16 or 256. The counter can be 16 or 32 bits wide and runs in one of three modes. In free-running mode it wraps to all-ones of the selected width. In periodic mode it wraps to a programmed reload value. In one-shot mode it halts at zero after a single expiry.

Software programs the block through a word-addressed register port. Reads are combinational from the current address, and a write strobe commits data at the clock edge. The reload value can be written in two ways. An immediate write also restarts the count at once. A deferred write changes only the value used at the next wrap. Each expiry sets a sticky raw status flag. The interrupt pin and the masked status both show that flag gated by an enable bit, and any write to the clear register removes it.

Top module: `dtimer_core`

## Requirements
- R1: After reset the control register reads 0x20 at offset 2, and the count (offset 1), the raw status (offset 4) and `irq` all read zero.
- R2: The control byte at offset 2 reads back as written (bits 7:0; upper bits read zero). Bit 7 is run, bit 6 is periodic, bit 5 is interrupt enable, bits 3:2 select the prescaler, bit 1 selects 32-bit width and bit 0 selects one-shot.
- R3: Prescaler code 01 gives one count step per 16 accepted ticks, code 10 per 256, and codes 00 and 11 per tick. A tick is accepted only when `tick_en` is high and run is set. Any control write restarts the prescaler phase.
- R4: A count step taken while the count is zero is an expiry and sets the raw status. After it, free-running mode (bits 6 and 0 both clear) reloads all-ones of the width, and periodic mode reloads the reload value masked to the width. A step at a non-zero count decrements by one.
- R5: In one-shot mode an expiry leaves the count at zero and no later step counts or expires. A Load write or a control write releases this halt.
- R6: A write to offset 0 (Load) sets the reload value and the count, masked to the current width. It overrides a count step in the same cycle.
- R7: A write to offset 6 (Background Load) sets only the reload value. The count goes on unchanged and takes the new value at its next wrap.
- R8: Any write to offset 3 clears the raw status. An expiry in the same cycle wins, and the status stays set.
- R9: Offset 4 reads the raw status in bit 0. Offset 5 and `irq` both show the raw status ANDed with the interrupt enable.
- R10: With bit 1 clear, only the low 16 bits count, wrap and compare to zero, and offset 1 reads bits 31:16 as zero.
- R11: Writes to offsets 1 and 7 change nothing. Offsets 0 and 6 read the same reload value. Offsets 3 and 7 read zero.
- R12: While run is clear, the count does not change except through a Load write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer tick qualifier, one pulse per timer clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt: raw status gated by enable |

## Verification
Two events can fall in the same cycle here. An expiry can meet an interrupt-clear write, and a count step can meet a Load write. The bench provokes both by watching its own model's count. It issues the clear write when the next step will land on zero, and it issues a Load write while ticks are flowing. It then judges that the raw status stays set and that the count equals the written value. A free-running reference model, compared on every cycle, also covers control writes that land on prescaler wrap cycles during a long mixed stimulus phase.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  localparam int REG_W    = 32;
  localparam int NARROW_W = 16;
  localparam int OFS_W    = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_LOAD   = 3'd0,
    OFS_VALUE  = 3'd1,
    OFS_CTRL   = 3'd2,
    OFS_ICLR   = 3'd3,
    OFS_RAW    = 3'd4,
    OFS_MSK    = 3'd5,
    OFS_BGLOAD = 3'd6
  } ofs_e;

  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       ie;
    logic       spare;
    logic [1:0] psel;
    logic       wide;
    logic       single;
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h20;

  function automatic int unsigned presc_last(input logic [1:0] sel);
    case (sel)
      2'b01:   return 32'd15;
      2'b10:   return 32'd255;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] cnt_mask(input logic wide);
    return wide ? {REG_W{1'b1}} : {{(REG_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  endfunction

  function automatic logic [REG_W-1:0] wrap_value(input ctrl_t c, input logic [REG_W-1:0] ld);
    if (!c.single && !c.periodic) return cnt_mask(c.wide);
    return ld & cnt_mask(c.wide);
  endfunction

  function automatic logic [REG_W-1:0] dec_value(input logic [REG_W-1:0] v, input logic wide);
    return (v - {{(REG_W-1){1'b0}}, 1'b1}) & cnt_mask(wide);
  endfunction

endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
  import dtmr_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] psel,
  output logic       step
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last;
  logic             at_last;

  assign last    = PRE_W'(presc_last(psel));
  assign at_last = (pre_q == last);
  assign step    = tick_en & run & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (restart)        pre_q <= '0;
    else if (tick_en && run) pre_q <= at_last ? '0 : pre_q + 1'b1;
  end

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n) pre_q <= last);

  // R3
  pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n) step |=> (pre_q == '0));

endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
  import dtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  ctrl_t            ctrl,
  input  logic [REG_W-1:0] reload_q,
  input  logic             load_wr,
  input  logic             ctrl_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cnt_view,
  output logic             expire
);

  logic [REG_W-1:0] cnt_q;
  logic [REG_W-1:0] mask;
  logic             done_q;
  logic             at_zero;
  logic             advance;

  assign mask     = cnt_mask(ctrl.wide);
  assign cnt_view = cnt_q & mask;
  assign at_zero  = (cnt_view == '0);
  assign advance  = step & ~done_q;
  assign expire   = advance & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load_wr)                cnt_q <= wdata & mask;
    else if (expire && !ctrl.single) cnt_q <= wrap_value(ctrl, reload_q);
    else if (advance && !at_zero)    cnt_q <= dec_value(cnt_q, ctrl.wide);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     done_q <= 1'b0;
    else if (load_wr || ctrl_wr)    done_q <= 1'b0;
    else if (expire && ctrl.single) done_q <= 1'b1;
  end

  // R5
  halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> at_zero);

  // R6
  load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt_q == $past(wdata & mask)));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/dtimer_core.sv
module dtimer_core
  import dtmr_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq
);

  ctrl_t            ctrl_q;
  logic [REG_W-1:0] reload_q;
  logic             raw_q;
  logic             load_wr, bg_wr, ctrl_wr, iclr_wr;
  logic             step, expire;
  logic [REG_W-1:0] cnt_view;

  assign load_wr = wr_en && (addr == OFS_LOAD);
  assign bg_wr   = wr_en && (addr == OFS_BGLOAD);
  assign ctrl_wr = wr_en && (addr == OFS_CTRL);
  assign iclr_wr = wr_en && (addr == OFS_ICLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= ctrl_t'(CTRL_RESET);
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[7:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 reload_q <= '0;
    else if (load_wr || bg_wr)  reload_q <= wdata;
  end

  dtmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .run     (ctrl_q.run),
    .restart (ctrl_wr),
    .psel    (ctrl_q.psel),
    .step    (step)
  );

  dtmr_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .ctrl     (ctrl_q),
    .reload_q (reload_q),
    .load_wr  (load_wr),
    .ctrl_wr  (ctrl_wr),
    .wdata    (wdata),
    .cnt_view (cnt_view),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       raw_q <= 1'b0;
    else if (expire)  raw_q <= 1'b1;
    else if (iclr_wr) raw_q <= 1'b0;
  end

  assign irq = raw_q & ctrl_q.ie;

  always_comb begin
    case (addr)
      OFS_LOAD, OFS_BGLOAD: rdata = reload_q;
      OFS_VALUE:            rdata = cnt_view;
      OFS_CTRL:             rdata = {{(REG_W-8){1'b0}}, ctrl_q};
      OFS_RAW:              rdata = {{(REG_W-1){1'b0}}, raw_q};
      OFS_MSK:              rdata = {{(REG_W-1){1'b0}}, irq};
      default:              rdata = '0;
    endcase
  end

  // R4
  raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n) expire |=> raw_q);

  // R8
  raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iclr_wr && !expire) |=> !raw_q);

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_q.run |-> !step);

  // R10
  narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.wide |-> (cnt_view[REG_W-1:NARROW_W] == '0));

endmodule

// File: tb/dtimer_core_test.sv
module dtimer_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  // reference state
  logic [7:0]  m_ctrl = 8'h20;
  logic [31:0] m_load = 0;
  logic [31:0] m_cnt = 0;
  int          m_pre = 0;
  logic        m_raw = 0;
  logic        m_halt = 0;

  always #10 clk = ~clk;

  dtimer_core uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] width_of(input logic [7:0] c);
    return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic int divisor(input logic [7:0] c);
    if (c[3:2] == 2'd1) return 16;
    if (c[3:2] == 2'd2) return 256;
    return 1;
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] a);
    if (a == 0 || a == 6) return m_load;
    if (a == 1) return m_cnt & width_of(m_ctrl);
    if (a == 2) return {24'd0, m_ctrl};
    if (a == 4) return {31'd0, m_raw};
    if (a == 5) return {31'd0, m_raw & m_ctrl[5]};
    return 0;
  endfunction

  task automatic model_step();
    logic [31:0] w = width_of(m_ctrl);
    bit stepped = 0;
    bit fired = 0;
    int npre = m_pre;
    logic [31:0] ncnt = m_cnt;
    logic nhalt = m_halt;
    if (tick_en && m_ctrl[7]) begin
      if (m_pre + 1 == divisor(m_ctrl)) begin stepped = 1; npre = 0; end
      else npre = m_pre + 1;
    end
    if (stepped && !m_halt) begin
      if ((m_cnt & w) == 0) begin
        fired = 1;
        if (m_ctrl[0]) nhalt = 1;
        else if (!m_ctrl[6]) ncnt = w;
        else ncnt = m_load & w;
      end else ncnt = ((m_cnt & w) - 1) & w;
    end
    if (wr_en) begin
      case (addr)
        3'd0: begin m_load = wdata; ncnt = wdata & w; nhalt = 0; end
        3'd2: begin m_ctrl = wdata[7:0]; npre = 0; nhalt = 0; end
        3'd3: if (!fired) m_raw = 0;
        3'd6: m_load = wdata;
        default: ;
      endcase
    end
    if (fired) m_raw = 1;
    m_cnt = ncnt; m_pre = npre; m_halt = nhalt;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 8'h20; m_load = 0; m_cnt = 0; m_pre = 0; m_raw = 0; m_halt = 0;
    end else model_step();
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rdata !== model_read(addr)) begin
        failures++;
        $display("FAIL %s rdata offset=%0d actual=%h expected=%h", phase, addr, rdata, model_read(addr));
      end
      checks++;
      if (irq !== (m_raw & m_ctrl[5])) begin
        failures++;
        $display("FAIL %s irq actual=%b expected=%b", phase, irq, m_raw & m_ctrl[5]);
      end
    end
  end

  task automatic cyc(input bit w, input logic [2:0] a, input logic [31:0] d, input bit t);
    @(posedge clk); #1;
    wr_en = w; addr = a; wdata = d; tick_en = t;
  endtask

  task automatic look(input string tag, input logic [2:0] a, input logic [31:0] exp);
    cyc(0, a, 0, 0);
    @(negedge clk);
    checks++;
    if (rdata !== exp) begin
      failures++;
      $display("FAIL %s offset=%0d actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    phase = "R1";
    look("R1", 3'd2, 32'h20);
    look("R1", 3'd1, 32'h0);
    look("R1", 3'd4, 32'h0);
    checks++;
    if (irq !== 1'b0) begin failures++; $display("FAIL R1 irq actual=%b expected=0", irq); end

    phase = "R2";
    cyc(1, 2, 32'hFFFF_FF5D, 0);
    look("R2", 3'd2, 32'h5D);
    cyc(1, 2, 32'h0000_00E0, 0);
    look("R2", 3'd2, 32'hE0);

    phase = "R6";
    cyc(1, 0, 32'd5, 1);
    repeat (3) cyc(0, 1, 0, 1);
    cyc(1, 0, 32'd100, 1);
    look("R6", 3'd1, 32'd100);
    cyc(1, 0, 32'd5, 0);

    phase = "R8";
    cyc(0, 1, 0, 1);
    while ((m_cnt & 32'hFFFF) != 1) cyc(0, 1, 0, 1);
    cyc(1, 3, 0, 1);
    look("R8", 3'd4, 32'd1);
    cyc(1, 3, 0, 0);
    look("R8", 3'd4, 32'd0);

    phase = "R9";
    cyc(1, 2, 32'hC0, 0);
    cyc(1, 0, 32'd1, 0);
    repeat (2) cyc(0, 4, 0, 1);
    look("R9", 3'd4, 32'd1);
    look("R9", 3'd5, 32'd0);
    checks++;
    if (irq !== 1'b0) begin failures++; $display("FAIL R9 irq actual=%b expected=0", irq); end
    cyc(1, 2, 32'hE0, 0);
    look("R9", 3'd5, 32'd1);
    cyc(1, 3, 0, 0);

    phase = "R3";
    cyc(1, 2, 32'hC6, 0);
    cyc(1, 0, 32'd3, 0);
    repeat (15) cyc(0, 1, 0, 1);
    look("R3", 3'd1, 32'd3);
    cyc(0, 1, 0, 1);
    look("R3", 3'd1, 32'd2);
    cyc(1, 2, 32'hCA, 0);
    cyc(1, 0, 32'd2, 0);
    repeat (255) cyc(0, 1, 0, 1);
    look("R3", 3'd1, 32'd2);
    cyc(0, 1, 0, 1);
    look("R3", 3'd1, 32'd1);
    cyc(1, 2, 32'hCE, 0);
    cyc(1, 0, 32'd2, 0);
    cyc(0, 1, 0, 1);
    look("R3", 3'd1, 32'd1);

    phase = "R4";
    cyc(1, 2, 32'h80, 0);
    cyc(1, 0, 32'd2, 0);
    repeat (3) cyc(0, 1, 0, 1);
    look("R4", 3'd1, 32'hFFFF);
    cyc(1, 2, 32'h82, 0);
    cyc(1, 0, 32'd0, 0);
    cyc(0, 1, 0, 1);
    look("R4", 3'd1, 32'hFFFF_FFFF);
    look("R4", 3'd4, 32'd1);
    cyc(1, 3, 0, 0);

    phase = "R10";
    cyc(1, 2, 32'h80, 0);
    cyc(1, 0, 32'h0001_2345, 0);
    look("R10", 3'd1, 32'h2345);
    cyc(0, 1, 0, 1);
    look("R10", 3'd1, 32'h2344);

    phase = "R7";
    cyc(1, 2, 32'hC2, 0);
    cyc(1, 0, 32'd4, 0);
    cyc(1, 6, 32'd9, 0);
    look("R7", 3'd1, 32'd4);
    look("R11", 3'd0, 32'd9);
    look("R11", 3'd6, 32'd9);
    repeat (5) cyc(0, 1, 0, 1);
    look("R7", 3'd1, 32'd9);

    phase = "R11";
    cyc(1, 1, 32'hDEAD, 0);
    look("R11", 3'd1, 32'd9);
    cyc(1, 7, 32'hBEEF, 0);
    look("R11", 3'd7, 32'd0);
    look("R11", 3'd3, 32'd0);
    look("R11", 3'd2, 32'hC2);

    phase = "R5";
    cyc(1, 3, 0, 0);
    cyc(1, 2, 32'hA3, 0);
    cyc(1, 0, 32'd2, 0);
    repeat (3) cyc(0, 1, 0, 1);
    look("R5", 3'd4, 32'd1);
    cyc(1, 3, 0, 0);
    repeat (20) cyc(0, 1, 0, 1);
    look("R5", 3'd4, 32'd0);
    look("R5", 3'd1, 32'd0);
    cyc(1, 0, 32'd1, 0);
    repeat (2) cyc(0, 1, 0, 1);
    look("R5", 3'd4, 32'd1);

    phase = "R12";
    cyc(1, 2, 32'h42, 0);
    cyc(1, 0, 32'd7, 0);
    repeat (30) cyc(0, 1, 0, 1);
    look("R12", 3'd1, 32'd7);

    phase = "R3";
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      bit w = ($urandom_range(0, 9) == 0);
      logic [31:0] d = $urandom();
      if (a == 3'd0 || a == 3'd6) d = d & 32'h3F;
      if (a == 3'd2) d = (d & 32'hF7) | 32'h80;
      cyc(w, a, d, $urandom_range(0, 3) != 0);
    end

    cyc(0, 0, 0, 0);
    @(negedge clk);
    finish_run();
  end

endmodule